// File: doc/BRIEF.md
# Receive Frame Status Classifier

This block sits on a 64-bit receive stream and watches each Ethernet frame, from the first destination-address byte through the last FCS byte. Every beat goes out again one clock later with an odd-parity bit. On the beat that closes a frame, sideband outputs report an error vector, a 4-bit frame-type code and a length word. The byte count, the header fields and the error flags are gathered as the beats arrive, so the report needs no buffering of the frame.

Frame byte n sits in lane n mod 8 of beat n/8. Lane k is data bits [8k+7:8k]. The length/type field is frame bytes 12 (high) and 13 (low). The MAC control opcode is bytes 14 (high) and 15 (low). Bit 0 of byte 0 marks a group (broadcast or multicast) destination. The FCS check is done upstream, and the result arrives as an input on the closing beat. The largest legal frame size is an input.

Top module: `rx_frame_status`

## Requirements
- R1: Each accepted input beat appears on the output one cycle later with the same data, keep and last. `m_parity` is set so that the 64 data bits plus the parity bit hold an odd number of ones.
- R2: On a closing beat, `m_ext[31:16]` holds the frame length in bytes (the sum of set keep bits over the frame). `m_ext[15:0]` holds the payload length, which is the frame length minus 18, or 0 when the frame is shorter than 18 bytes.
- R3: Error bit 2 is set when the frame length is below 64 or above `max_frame_len`. Error bit 3 is set only when the length is above `max_frame_len`. A frame exactly `max_frame_len` long sets neither bit.
- R4: Error bit 4 is set when the length/type value lies in 46..1500 and is larger than the payload length.
- R5: Error bits 5 and 1 are both set when `s_fcs_ok` is low on the closing beat.
- R6: Error bit 0 is set when `s_ctrl_err` is high on the closing beat. Error bit 6 is set when `s_phy_err` was high on any beat of the frame.
- R7: A frame whose type is 0x8808 gets code 1001 when its opcode is 0x0001, code 0100 when its opcode is 0x0101, and code 0111 for any other opcode.
- R8: Frames that are not control frames are coded by priority, highest first:
  - 0011 for type 0x88F7.
  - 0101 for type 0x8100 or 0x88A8.
  - 0110 for a value below 0x0600 that lies outside 46..1500.
  - 0010 for a group destination.
  - 0000 otherwise.
  
  Header bytes that lie past the end of the frame read as zero.
- R9: After reset, and on every output beat that does not close a frame, the error vector, code and length word are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_tvalid | input | 1 | Input beat valid |
| s_tdata | input | 64 | Input beat data |
| s_tkeep | input | 8 | Input byte enables |
| s_tlast | input | 1 | Input beat closes the frame |
| s_ctrl_err | input | 1 | Beat carries a bad control block |
| s_phy_err | input | 1 | Beat carries a line-side error |
| s_fcs_ok | input | 1 | FCS check result, read on the closing beat |
| max_frame_len | input | 16 | Largest legal frame length in bytes |
| m_tvalid | output | 1 | Output beat valid |
| m_tdata | output | 64 | Output beat data |
| m_tkeep | output | 8 | Output byte enables |
| m_tlast | output | 1 | Output beat closes the frame |
| m_parity | output | 1 | Odd-parity bit for the output beat |
| m_err | output | 7 | Error vector: PHY, CRC, length, oversize, size range, FCS, malformed (bit 6 down to 0) |
| m_status | output | 4 | Frame-type code |
| m_ext | output | 32 | Frame length [31:16], payload length [15:0] |

## Verification
The assertions take three things for granted about the input:
- Keep bits are contiguous from lane 0.
- Every beat except the closing one is full.
- No frame reaches 65535 bytes, so the byte count never saturates.

The bench builds each frame from a byte list and derives the keep from the remaining length, so every beat meets these rules. Idle gaps between beats are allowed, and the bench inserts them in some frames. Under these conditions the reported length equals the number of bytes sent.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    typedef enum logic [3:0] {
        CODE_DATA    = 4'b0000,
        CODE_GROUP   = 4'b0010,
        CODE_PTP     = 4'b0011,
        CODE_PFC     = 4'b0100,
        CODE_VLAN    = 4'b0101,
        CODE_ILLEGAL = 4'b0110,
        CODE_CTRL    = 4'b0111,
        CODE_RSVD    = 4'b1000,
        CODE_PAUSE   = 4'b1001
    } rfs_code_e;

    // Bit 6 down to bit 0 of the reported error vector.
    typedef struct packed {
        logic phy;
        logic crc;
        logic len;
        logic over;
        logic range;
        logic fcs;
        logic malformed;
    } rfs_err_t;

    typedef struct packed {
        logic [7:0]  da0;
        logic [15:0] etype;
        logic [15:0] opcode;
    } rfs_hdr_t;

    localparam logic [15:0] ET_MACCTL = 16'h8808;
    localparam logic [15:0] ET_PTP    = 16'h88F7;
    localparam logic [15:0] ET_CVLAN  = 16'h8100;
    localparam logic [15:0] ET_SVLAN  = 16'h88A8;
    localparam logic [15:0] OP_PAUSE  = 16'h0001;
    localparam logic [15:0] OP_PFC    = 16'h0101;
    localparam logic [15:0] TYPE_BASE = 16'h0600;
    localparam logic [15:0] PAY_MIN   = 16'd46;
    localparam logic [15:0] PAY_MAX   = 16'd1500;

    localparam int MIN_FRAME   = 64;
    localparam int HDR_FCS_OVH = 18;

    // Frame byte positions of the captured header bytes.
    localparam int HDR_BYTES    = 5;
    localparam int HDR_LAST_POS = 15;

    function automatic int hdr_pos(input int idx);
        case (idx)
            0:       return 0;
            1:       return 12;
            2:       return 13;
            3:       return 14;
            default: return 15;
        endcase
    endfunction

endpackage

// File: rtl/rfs_len_track.sv
module rfs_len_track #(
    parameter int KEEP_W   = 8,
    parameter int LEN_W    = 16,
    parameter int BEAT_SAT = 2,
    parameter int BEAT_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_vld,
    input  logic              beat_last,
    input  logic [KEEP_W-1:0] keep,
    input  logic              phy_err,
    output logic [BEAT_W-1:0] beat_idx,
    output logic [LEN_W-1:0]  len_now,
    output logic              phy_now
);

    typedef struct packed {
        logic [LEN_W-1:0]  count;
        logic [BEAT_W-1:0] beat;
        logic              phy;
    } trk_t;

    trk_t trk_d, trk_q;

    logic [LEN_W:0]   sum_wide;
    logic [LEN_W-1:0] sum_sat;

    always_comb begin
        sum_wide = {1'b0, trk_q.count} + (LEN_W+1)'($countones(keep));
        sum_sat  = sum_wide[LEN_W] ? '1 : sum_wide[LEN_W-1:0];
        len_now  = sum_sat;
        phy_now  = trk_q.phy | (beat_vld & phy_err);
        beat_idx = trk_q.beat;

        trk_d = trk_q;
        if (beat_vld) begin
            if (beat_last) begin
                trk_d = '0;
            end else begin
                trk_d.count = sum_sat;
                trk_d.phy   = phy_now;
                if (trk_q.beat != BEAT_W'(BEAT_SAT)) begin
                    trk_d.beat = trk_q.beat + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

endmodule

// File: rtl/rfs_hdr_capture.sv
module rfs_hdr_capture
    import rfs_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_vld,
    input  logic              beat_last,
    input  logic [BEAT_W-1:0] beat_idx,
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W/8-1:0] keep,
    output rfs_hdr_t          hdr_now
);

    localparam int KEEP_W = DATA_W / 8;

    logic [HDR_BYTES-1:0][7:0] byte_d, byte_q;
    logic [HDR_BYTES-1:0][7:0] view;
    logic [HDR_BYTES-1:0]      hit;

    for (genvar g = 0; g < HDR_BYTES; g++) begin : g_hdr
        localparam int POS  = hdr_pos(g);
        localparam int BEAT = POS / KEEP_W;
        localparam int LANE = POS % KEEP_W;
        assign hit[g]  = beat_vld && (beat_idx == BEAT_W'(BEAT)) && keep[LANE];
        assign view[g] = hit[g] ? data[LANE*8 +: 8] : byte_q[g];
    end

    always_comb begin
        byte_d = byte_q;
        for (int i = 0; i < HDR_BYTES; i++) begin
            if (beat_vld && beat_last) byte_d[i] = '0;
            else if (hit[i])           byte_d[i] = view[i];
        end
        hdr_now.da0    = view[0];
        hdr_now.etype  = {view[1], view[2]};
        hdr_now.opcode = {view[3], view[4]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) byte_q <= '0;
        else        byte_q <= byte_d;
    end

endmodule

// File: rtl/rfs_classify.sv
module rfs_classify
    import rfs_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  rfs_hdr_t         hdr,
    input  logic [LEN_W-1:0] frame_len,
    input  logic [LEN_W-1:0] max_len,
    input  logic             fcs_ok,
    input  logic             ctrl_err,
    input  logic             phy_seen,
    output rfs_code_e        code,
    output rfs_err_t         err,
    output logic [LEN_W-1:0] payload_len
);

    logic is_len_field, len_legal, is_ctrl, is_vlan, too_long, too_short;

    always_comb begin
        payload_len  = (frame_len >= LEN_W'(HDR_FCS_OVH)) ?
                       frame_len - LEN_W'(HDR_FCS_OVH) : '0;
        is_len_field = hdr.etype < TYPE_BASE;
        len_legal    = is_len_field && (hdr.etype >= PAY_MIN) && (hdr.etype <= PAY_MAX);
        is_ctrl      = hdr.etype == ET_MACCTL;
        is_vlan      = (hdr.etype == ET_CVLAN) || (hdr.etype == ET_SVLAN);
        too_long     = frame_len > max_len;
        too_short    = frame_len < LEN_W'(MIN_FRAME);

        err.phy       = phy_seen;
        err.crc       = !fcs_ok;
        err.len       = len_legal && (LEN_W'(hdr.etype) > payload_len);
        err.over      = too_long;
        err.range     = too_long || too_short;
        err.fcs       = !fcs_ok;
        err.malformed = ctrl_err;

        if (is_ctrl && hdr.opcode == OP_PAUSE)   code = CODE_PAUSE;
        else if (is_ctrl && hdr.opcode == OP_PFC) code = CODE_PFC;
        else if (is_ctrl)                        code = CODE_CTRL;
        else if (hdr.etype == ET_PTP)            code = CODE_PTP;
        else if (is_vlan)                        code = CODE_VLAN;
        else if (is_len_field && !len_legal)     code = CODE_ILLEGAL;
        else if (hdr.da0[0])                     code = CODE_GROUP;
        else                                     code = CODE_DATA;
    end

endmodule

// File: rtl/rx_frame_status.sv
module rx_frame_status
    import rfs_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LEN_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 s_tvalid,
    input  logic [DATA_W-1:0]    s_tdata,
    input  logic [DATA_W/8-1:0]  s_tkeep,
    input  logic                 s_tlast,
    input  logic                 s_ctrl_err,
    input  logic                 s_phy_err,
    input  logic                 s_fcs_ok,
    input  logic [LEN_W-1:0]     max_frame_len,
    output logic                 m_tvalid,
    output logic [DATA_W-1:0]    m_tdata,
    output logic [DATA_W/8-1:0]  m_tkeep,
    output logic                 m_tlast,
    output logic                 m_parity,
    output logic [6:0]           m_err,
    output logic [3:0]           m_status,
    output logic [2*LEN_W-1:0]   m_ext
);

    localparam int KEEP_W   = DATA_W / 8;
    localparam int BEAT_SAT = HDR_LAST_POS / KEEP_W + 1;
    localparam int BEAT_W   = $clog2(BEAT_SAT + 1);

    typedef struct packed {
        logic               vld;
        logic [DATA_W-1:0]  data;
        logic [KEEP_W-1:0]  keep;
        logic               last;
        logic               par;
        rfs_err_t           err;
        rfs_code_e          code;
        logic [2*LEN_W-1:0] ext;
    } out_t;

    out_t out_d, out_q;

    logic [BEAT_W-1:0] beat_idx;
    logic [LEN_W-1:0]  len_now, payload_len;
    logic              phy_now;
    rfs_hdr_t          hdr_now;
    rfs_code_e         code;
    rfs_err_t          err;

    rfs_len_track #(
        .KEEP_W(KEEP_W), .LEN_W(LEN_W), .BEAT_SAT(BEAT_SAT), .BEAT_W(BEAT_W)
    ) u_len (
        .clk(clk), .rst_n(rst_n), .beat_vld(s_tvalid), .beat_last(s_tlast),
        .keep(s_tkeep), .phy_err(s_phy_err),
        .beat_idx(beat_idx), .len_now(len_now), .phy_now(phy_now)
    );

    rfs_hdr_capture #(
        .DATA_W(DATA_W), .BEAT_W(BEAT_W)
    ) u_hdr (
        .clk(clk), .rst_n(rst_n), .beat_vld(s_tvalid), .beat_last(s_tlast),
        .beat_idx(beat_idx), .data(s_tdata), .keep(s_tkeep), .hdr_now(hdr_now)
    );

    rfs_classify #(
        .LEN_W(LEN_W)
    ) u_cls (
        .hdr(hdr_now), .frame_len(len_now), .max_len(max_frame_len),
        .fcs_ok(s_fcs_ok), .ctrl_err(s_ctrl_err), .phy_seen(phy_now),
        .code(code), .err(err), .payload_len(payload_len)
    );

    always_comb begin
        out_d = '0;
        if (s_tvalid) begin
            out_d.vld  = 1'b1;
            out_d.data = s_tdata;
            out_d.keep = s_tkeep;
            out_d.last = s_tlast;
            out_d.par  = ~^s_tdata;
            if (s_tlast) begin
                out_d.err  = err;
                out_d.code = code;
                out_d.ext  = {len_now, payload_len};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign m_tvalid = out_q.vld;
    assign m_tdata  = out_q.data;
    assign m_tkeep  = out_q.keep;
    assign m_tlast  = out_q.last;
    assign m_parity = out_q.par;
    assign m_err    = out_q.err;
    assign m_status = out_q.code;
    assign m_ext    = out_q.ext;

endmodule

// File: rtl/rx_frame_status_chk.sv
module rx_frame_status_chk #(
    parameter int DATA_W = 64,
    parameter int LEN_W  = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               s_tvalid,
    input logic [DATA_W-1:0]  s_tdata,
    input logic               m_tvalid,
    input logic [DATA_W-1:0]  m_tdata,
    input logic               m_tlast,
    input logic               m_parity,
    input logic [6:0]         m_err,
    input logic [3:0]         m_status,
    input logic [2*LEN_W-1:0] m_ext
);

    // R1
    beat_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_tvalid |=> (m_tvalid && m_tdata == $past(s_tdata)));

    // R1
    parity_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> (^{m_tdata, m_parity}) == 1'b1);

    // R2
    payload_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && m_tlast) |-> (m_ext[LEN_W-1:0] <= m_ext[2*LEN_W-1:LEN_W]));

    // R3
    oversize_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_err[3] |-> m_err[2]);

    // R3
    short_frame_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && m_tlast && m_ext[2*LEN_W-1:LEN_W] < LEN_W'(64)) |-> m_err[2]);

    // R5
    crc_fcs_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_err[5] == m_err[1]);

    // R9
    quiet_midframe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(m_tvalid && m_tlast) |-> (m_err == '0 && m_status == '0 && m_ext == '0));

endmodule

bind rx_frame_status rx_frame_status_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .s_tvalid(s_tvalid), .s_tdata(s_tdata),
    .m_tvalid(m_tvalid), .m_tdata(m_tdata), .m_tlast(m_tlast), .m_parity(m_parity),
    .m_err(m_err), .m_status(m_status), .m_ext(m_ext)
);

// File: tb/rx_frame_status_test.sv
module rx_frame_status_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_tvalid = 1'b0;
    logic [63:0] s_tdata = '0;
    logic [7:0]  s_tkeep = '0;
    logic        s_tlast = 1'b0;
    logic        s_ctrl_err = 1'b0;
    logic        s_phy_err = 1'b0;
    logic        s_fcs_ok = 1'b1;
    logic [15:0] max_frame_len = 16'd1518;
    logic        m_tvalid, m_tlast, m_parity;
    logic [63:0] m_tdata;
    logic [7:0]  m_tkeep;
    logic [6:0]  m_err;
    logic [3:0]  m_status;
    logic [31:0] m_ext;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [63:0] d;
        logic [7:0]  k;
        logic        last;
        logic [6:0]  err;
        logic [3:0]  code;
        logic [31:0] ext;
    } beat_t;

    beat_t exp_q[$];
    logic [7:0] fb [0:2047];

    always #2.5 clk = ~clk;

    rx_frame_status uut (
        .clk(clk), .rst_n(rst_n), .s_tvalid(s_tvalid), .s_tdata(s_tdata),
        .s_tkeep(s_tkeep), .s_tlast(s_tlast), .s_ctrl_err(s_ctrl_err),
        .s_phy_err(s_phy_err), .s_fcs_ok(s_fcs_ok), .max_frame_len(max_frame_len),
        .m_tvalid(m_tvalid), .m_tdata(m_tdata), .m_tkeep(m_tkeep), .m_tlast(m_tlast),
        .m_parity(m_parity), .m_err(m_err), .m_status(m_status), .m_ext(m_ext)
    );

    task automatic check(input bit ok, input string what, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [7:0] fbyte(input int i, input int n);
        return (i < n) ? fb[i] : 8'h00;
    endfunction

    // Sends one frame of n bytes and queues the expected output beats.
    task automatic send_frame(input int n, input logic [7:0] da0, input logic [15:0] et,
                              input logic [15:0] op, input bit fcs_ok, input bit cerr,
                              input int phy_beat, input bit gaps);
        int nb;
        logic [15:0] etv, opv, pay;
        logic [6:0] e;
        logic [3:0] c;
        bit lenf, legal, ctl;
        for (int i = 0; i < n; i++) fb[i] = 8'((i * 29 + n) & 8'hFF);
        fb[0] = da0;
        fb[12] = et[15:8];  fb[13] = et[7:0];
        fb[14] = op[15:8];  fb[15] = op[7:0];
        etv = {fbyte(12, n), fbyte(13, n)};
        opv = {fbyte(14, n), fbyte(15, n)};
        pay = (n >= 18) ? 16'(n - 18) : 16'd0;
        lenf  = etv < 16'h0600;
        legal = lenf && etv >= 16'd46 && etv <= 16'd1500;
        ctl   = etv == 16'h8808;
        nb = (n + 7) / 8;
        // R6 phy bit, R5 crc, R4 len, R3 over/range, R5 fcs, R6 malformed
        e[6] = (phy_beat >= 0 && phy_beat < nb);
        e[5] = !fcs_ok;
        e[4] = legal && (etv > pay);
        e[3] = 16'(n) > max_frame_len;
        e[2] = (16'(n) > max_frame_len) || (n < 64);
        e[1] = !fcs_ok;
        e[0] = cerr;
        // R7 control codes, R8 remaining codes
        if (ctl && opv == 16'h0001)                      c = 4'b1001;
        else if (ctl && opv == 16'h0101)                 c = 4'b0100;
        else if (ctl)                                    c = 4'b0111;
        else if (etv == 16'h88F7)                        c = 4'b0011;
        else if (etv == 16'h8100 || etv == 16'h88A8)     c = 4'b0101;
        else if (lenf && !legal)                         c = 4'b0110;
        else if (fbyte(0, n) & 8'h01)                    c = 4'b0010;
        else                                             c = 4'b0000;
        for (int b = 0; b < nb; b++) begin
            beat_t x;
            x.d = '0; x.k = '0;
            for (int l = 0; l < 8; l++) begin
                if (b * 8 + l < n) begin
                    x.d[l*8 +: 8] = fb[b*8 + l];
                    x.k[l] = 1'b1;
                end
            end
            x.last = (b == nb - 1);
            x.err  = x.last ? e : 7'd0;
            x.code = x.last ? c : 4'd0;
            x.ext  = x.last ? {16'(n), pay} : 32'd0;
            if (gaps && b[0]) begin
                @(negedge clk);
                s_tvalid = 1'b0; s_tdata = '0; s_tkeep = '0; s_tlast = 1'b0;
                s_phy_err = 1'b0; s_ctrl_err = 1'b0;
            end
            @(negedge clk);
            exp_q.push_back(x);
            s_tvalid   = 1'b1;
            s_tdata    = x.d;
            s_tkeep    = x.k;
            s_tlast    = x.last;
            s_phy_err  = (b == phy_beat);
            s_ctrl_err = x.last && cerr;
            s_fcs_ok   = x.last ? fcs_ok : 1'b1;
        end
        @(negedge clk);
        s_tvalid = 1'b0; s_tdata = '0; s_tkeep = '0; s_tlast = 1'b0;
        s_phy_err = 1'b0; s_ctrl_err = 1'b0; s_fcs_ok = 1'b1;
    endtask

    // Monitor: pops one expected beat per output beat.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && m_tvalid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1 unexpected beat", {63'd0, m_tvalid}, 64'd0);
                end else begin
                    beat_t x;
                    x = exp_q.pop_front();
                    // R1 data, keep, last and parity
                    check(m_tdata == x.d, "R1 data", m_tdata, x.d);
                    check(m_tkeep == x.k && m_tlast == x.last, "R1 keep/last",
                          {m_tkeep, m_tlast}, {x.k, x.last});
                    check((^{m_tdata, m_parity}) == 1'b1, "R1 parity", {63'd0, m_parity},
                          {63'd0, ~^x.d});
                    if (x.last) begin
                        check(m_err == x.err, "R3 R4 R5 R6 err", {57'd0, m_err}, {57'd0, x.err});
                        check(m_status == x.code, "R7 R8 code", {60'd0, m_status},
                              {60'd0, x.code});
                        check(m_ext == x.ext, "R2 lengths", {32'd0, m_ext}, {32'd0, x.ext});
                    end else begin
                        check(m_err == 0 && m_status == 0 && m_ext == 0, "R9 quiet",
                              {21'd0, m_err, m_status, m_ext}, 64'd0);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check(!m_tvalid && m_err == 0 && m_status == 0 && m_ext == 0, "R9 reset",
              {21'd0, m_err, m_status, m_ext}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R8 plain data, group, PTP, VLAN over group, SVLAN
        send_frame(64,  8'h00, 16'h0800, 16'h0000, 1, 0, -1, 0);
        send_frame(100, 8'hFF, 16'h0800, 16'h0000, 1, 0, -1, 0);
        send_frame(70,  8'h02, 16'h88F7, 16'h0000, 1, 0, -1, 1);
        send_frame(68,  8'h01, 16'h8100, 16'h0000, 1, 0, -1, 0);
        send_frame(64,  8'h00, 16'h88A8, 16'h0000, 1, 0, -1, 0);
        // R7 pause, PFC, other control
        send_frame(64,  8'h01, 16'h8808, 16'h0001, 1, 0, -1, 0);
        send_frame(64,  8'h01, 16'h8808, 16'h0101, 1, 0, -1, 1);
        send_frame(64,  8'h01, 16'h8808, 16'h0002, 1, 0, -1, 0);
        // R4 length field: exact fit, longer than received; R8 illegal values
        send_frame(64,  8'h00, 16'd46,   16'h0000, 1, 0, -1, 0);
        send_frame(64,  8'h00, 16'd100,  16'h0000, 1, 0, -1, 0);
        send_frame(64,  8'h01, 16'd16,   16'h0000, 1, 0, -1, 0);
        send_frame(80,  8'h00, 16'd1501, 16'h0000, 1, 0, -1, 0);
        // R3 undersize, max exactly, one over, programmed small max
        send_frame(60,  8'h00, 16'h0800, 16'h0000, 1, 0, -1, 0);
        send_frame(1518, 8'h00, 16'h0800, 16'h0000, 1, 0, -1, 0);
        send_frame(1519, 8'h00, 16'h0800, 16'h0000, 1, 0, -1, 0);
        max_frame_len = 16'd100;
        send_frame(101, 8'h00, 16'h0800, 16'h0000, 1, 0, -1, 0);
        send_frame(100, 8'h00, 16'h0800, 16'h0000, 1, 0, -1, 0);
        max_frame_len = 16'd1518;
        // R5 bad FCS, R6 control error on last beat, line error mid frame
        send_frame(72,  8'h00, 16'h0800, 16'h0000, 0, 0, -1, 0);
        send_frame(72,  8'h00, 16'h0800, 16'h0000, 1, 1, -1, 0);
        send_frame(96,  8'h00, 16'h0800, 16'h0000, 1, 0, 5, 1);
        // R8 header past frame end, frame ending on the type beat; R2 short payload
        send_frame(10,  8'h00, 16'h88F7, 16'h0000, 1, 0, -1, 0);
        send_frame(16,  8'h00, 16'h88F7, 16'h0000, 1, 0, -1, 0);
        send_frame(13,  8'h01, 16'h88F7, 16'h0000, 1, 0, -1, 0);
        // R6 line error does not leak into the next frame
        send_frame(64,  8'h00, 16'h0800, 16'h0000, 1, 0, -1, 0);
        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R1 all beats seen", 64'(exp_q.size()), 64'd0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule